// File: doc/BRIEF.md
# Serial Instruction Receiver with Start-Bit Framing

This block sits at the serial port of a small RAM device that is shadowed by nonvolatile storage. The port has three wires: a select line, a serial clock and a serial data line. The block samples these lines in a fast system clock domain. While the select line is high, the block throws away zero bits until the first one bit arrives. That one bit is the first bit of an 8-bit instruction, sent most significant bit first. After the remaining seven bits arrive, the block splits the word into a 4-bit RAM address and a 3-bit operation code. It then reports the decoded operation with a one-cycle strobe.

The serial clock has no minimum rate and may stop at any point without loss of state. Once the block has delivered an instruction, it ignores further bits until the select line goes low. Dropping the select line also abandons any instruction that is only partly received. A busy signal from the store controller suppresses the strobe, and an instruction that completes while busy is high is discarded.

Top module: `serial_cmd_rx`

## Requirements
- R1: After reset, `cmd_valid` is low and stays low until a complete instruction has been framed.
- R2: While `ce` is high and no instruction has started, bits clocked in with `sdi` low are discarded. The first bit clocked in with `sdi` high is taken as the instruction's most significant bit.
- R3: Bits are taken on rising edges of `sck`, most significant bit first. `cmd_addr` reports instruction bits 6..3, with bit 6 as the address MSB.
- R4: Instruction bits 2..0 decode to `cmd_op` as follows: 000→0 (disable writes), 001→1 (save RAM to nonvolatile), 010→2 (enable automatic save), 011→3 (RAM write), 100→4 (enable writes), 101→5 (restore from nonvolatile), 110 and 111→6 (RAM read).
- R5: `cmd_valid` is high for exactly one `clk` cycle. It rises on the third `clk` rising edge after the `sck` rising edge that carries the eighth bit.
- R6: After an instruction completes, further `sck` edges produce no strobe until `ce` has gone low.
- R7: `ce` going low discards a partly received instruction. Framing restarts from the start-bit search when `ce` is next high.
- R8: `sck` may stay stopped for any number of `clk` cycles partway through an instruction. Shifting resumes correctly when it restarts.
- R9: An instruction that completes while `busy` is high produces no strobe.
- R10: `sck` edges that arrive while `ce` is low have no effect on the next instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Serial select; high for the whole transfer |
| sck | input | 1 | Serial clock, asynchronous and static |
| sdi | input | 1 | Serial data in |
| busy | input | 1 | Store controller busy; drops completed instructions |
| cmd_valid | output | 1 | One-cycle strobe for a decoded instruction |
| cmd_op | output | 3 | Decoded operation code (see R4) |
| cmd_addr | output | 4 | RAM address field of the instruction |

## Verification
The strobe is due three `clk` edges after the `sck` rise that carries the final bit. This delay comes from two synchronizer flops and the framing register. The latency test counts those edges one at a time and samples at each falling edge, expecting low, low, high, then low. All other tests wait well past that point before they compare the captured operation and address. A bench monitor counts strobes and flags any strobe that lasts two cycles. This lets each test check that exactly the expected number of instructions came out, or none at all.

// File: rtl/serial_cmd_pkg.sv
// Shared types for the serial instruction receiver.
// Assumes a fixed 3-bit operation field in the instruction.
package serial_cmd_pkg;
    localparam int OP_W = 3;

    typedef enum logic [2:0] {
        OP_WRITE_OFF  = 3'd0,
        OP_SAVE       = 3'd1,
        OP_AUTOSAVE   = 3'd2,
        OP_RAM_WRITE  = 3'd3,
        OP_WRITE_ON   = 3'd4,
        OP_RESTORE    = 3'd5,
        OP_RAM_READ   = 3'd6
    } cmd_e;
endpackage

// File: rtl/serial_line_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous single-bit lines.
// Assumes each line is independent; no multi-bit coherence is implied.
module serial_line_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // First stage captures the raw asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            // Each later stage reduces the metastability window further.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/serial_cmd_framer.sv
// Start-bit search and MSB-first shift framer, working on synchronized lines.
// Assumes ce/sck/sdi are already synchronized to clk. The start bit is not
// stored; word_q holds the INSTR_W-1 bits that follow it.
module serial_cmd_framer #(
    parameter int INSTR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce_s,
    input  logic               sck_s,
    input  logic               sdi_s,
    input  logic               busy,
    output logic               done_q,
    output logic [INSTR_W-2:0] word_q
);
    localparam int CNT_W = $clog2(INSTR_W);
    localparam int SH_W  = INSTR_W - 2;

    typedef enum logic [1:0] {ST_HUNT, ST_SHIFT, ST_HOLD} fr_state_e;

    fr_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [SH_W-1:0]  shreg;
    logic             sck_prev;
    logic             sck_rise;

    // Remember the previous sck sample so that rising edges can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_s;
    end

    assign sck_rise = sck_s & ~sck_prev;

    // Framing state machine: hunt for the start bit, shift, then hold until deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_HUNT;
            cnt    <= '0;
            shreg  <= '0;
            done_q <= 1'b0;
            word_q <= '0;
        end else if (!ce_s) begin
            state  <= ST_HUNT;
            cnt    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (sck_rise) begin
                case (state)
                    ST_HUNT: begin
                        if (sdi_s) begin
                            shreg <= '0;
                            cnt   <= CNT_W'(1);
                            state <= ST_SHIFT;
                        end
                    end
                    ST_SHIFT: begin
                        cnt <= cnt + CNT_W'(1);
                        if (cnt == CNT_W'(INSTR_W - 1)) begin
                            word_q <= {shreg, sdi_s};
                            done_q <= ~busy;
                            state  <= ST_HOLD;
                        end else begin
                            shreg <= {shreg[SH_W-2:0], sdi_s};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/serial_cmd_decode.sv
// Maps the 3-bit operation field to the command enumeration.
// Assumes both codes 110 and 111 denote a RAM read.
module serial_cmd_decode
    import serial_cmd_pkg::*;
(
    input  logic [OP_W-1:0] op_bits,
    output cmd_e            op
);
    // Pure combinational lookup of the operation.
    always_comb begin
        case (op_bits)
            3'b000:  op = OP_WRITE_OFF;
            3'b001:  op = OP_SAVE;
            3'b010:  op = OP_AUTOSAVE;
            3'b011:  op = OP_RAM_WRITE;
            3'b100:  op = OP_WRITE_ON;
            3'b101:  op = OP_RESTORE;
            default: op = OP_RAM_READ;
        endcase
    end
endmodule

// File: rtl/serial_cmd_rx.sv
// Top level of the serial instruction receiver: synchronizes the port,
// frames the instruction and decodes its fields.
// Assumes busy is already synchronous to clk.
module serial_cmd_rx
    import serial_cmd_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              sck,
    input  logic              sdi,
    input  logic              busy,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr
);
    localparam int INSTR_W = 1 + ADDR_W + OP_W;

    logic [2:0]         lines_s;
    logic               done;
    logic [INSTR_W-2:0] word;
    cmd_e               dec_op;

    serial_line_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ce, sck, sdi}),
        .q     (lines_s)
    );

    serial_cmd_framer #(.INSTR_W(INSTR_W)) u_framer (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_s   (lines_s[2]),
        .sck_s  (lines_s[1]),
        .sdi_s  (lines_s[0]),
        .busy   (busy),
        .done_q (done),
        .word_q (word)
    );

    serial_cmd_decode u_dec (
        .op_bits (word[OP_W-1:0]),
        .op      (dec_op)
    );

    assign cmd_valid = done;
    assign cmd_op    = dec_op;
    assign cmd_addr  = word[INSTR_W-2 -: ADDR_W];
endmodule

// File: rtl/serial_cmd_rx_chk.sv
// Assertion checker for serial_cmd_rx, attached with bind.
// Assumes the default two-stage synchronizer, which fixes the port-to-strobe delay.
module serial_cmd_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic ce,
    input logic sck,
    input logic busy,
    input logic cmd_valid
);
    logic issued;

    // Track whether a strobe was issued since ce was last low.
    always_ff @(posedge clk) begin
        if (!rst_n || !ce) issued <= 1'b0;
        else if (cmd_valid) issued <= 1'b1;
    end

    p_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    p_sck_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($past(sck, 3) && !$past(sck, 4)));

    p_ce_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(ce, 3));

    p_no_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !$past(busy));

    p_once_per_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !issued);
endmodule

bind serial_cmd_rx serial_cmd_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce        (ce),
    .sck       (sck),
    .busy      (busy),
    .cmd_valid (cmd_valid)
);

// File: tb/test_serial_cmd_rx.sv
module test_serial_cmd_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce = 1'b0;
    logic       sck = 1'b0;
    logic       sdi = 1'b0;
    logic       busy = 1'b0;
    logic       cmd_valid;
    logic [2:0] cmd_op;
    logic [3:0] cmd_addr;

    int n_checks = 0;
    int n_fail   = 0;
    int pulses   = 0;
    int wide     = 0;
    logic [2:0] last_op = '0;
    logic [3:0] last_addr = '0;
    logic       prev_valid = 1'b0;

    always #10 clk = ~clk;

    serial_cmd_rx i_serial_cmd_rx (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sck(sck), .sdi(sdi),
        .busy(busy), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr)
    );

    // Strobe monitor: counts strobes, captures fields and flags wide pulses.
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            pulses    <= pulses + 1;
            last_op   <= cmd_op;
            last_addr <= cmd_addr;
            if (prev_valid) wide <= wide + 1;
        end
        prev_valid <= cmd_valid;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        sdi = b;
        tick(3);
        sck = 1'b1;
        tick(4);
        sck = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic select(input bit v);
        ce = v;
        tick(5);
    endtask

    function automatic int exp_op(input logic [7:0] b);
        return (b[2:0] == 3'd7) ? 6 : int'(b[2:0]);
    endfunction

    task automatic expect_cmd(input int p0, input logic [7:0] b, input string req);
        tick(6);
        check(pulses == p0 + 1, req, pulses - p0, 1);
        check(int'(last_op) == exp_op(b), req, last_op, exp_op(b));
        check(last_addr == b[6:3], req, last_addr, b[6:3]);
    endtask

    task automatic t_reset;
        tick(1);
        check(cmd_valid == 1'b0, "R1", cmd_valid, 0);
        rst_n = 1'b1;
        tick(20);
        check(pulses == 0 && cmd_valid == 1'b0, "R1", pulses, 0);
    endtask

    task automatic t_all_ops;
        for (int c = 0; c < 8; c++) begin
            logic [7:0] b;
            int p0;
            b  = {1'b1, 4'(c * 3 + 5), 3'(c)};
            p0 = pulses;
            select(1);
            send_byte(b);
            expect_cmd(p0, b, "R4/R3");
            select(0);
        end
    endtask

    task automatic t_leading_zeros;
        logic [7:0] b = 8'b1_1010_110;
        int p0 = pulses;
        select(1);
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        send_byte(b);
        expect_cmd(p0, b, "R2");
        select(0);
    endtask

    task automatic t_latency;
        logic [7:0] b = 8'b1_0110_011;
        int p0 = pulses;
        select(1);
        for (int i = 7; i >= 1; i--) send_bit(b[i]);
        sdi = b[0];
        tick(3);
        sck = 1'b1;
        tick(1); check(cmd_valid == 1'b0, "R5 edge1", cmd_valid, 0);
        tick(1); check(cmd_valid == 1'b0, "R5 edge2", cmd_valid, 0);
        tick(1); check(cmd_valid == 1'b1, "R5 edge3", cmd_valid, 1);
        tick(1); check(cmd_valid == 1'b0, "R5 width", cmd_valid, 0);
        sck = 1'b0;
        expect_cmd(p0, b, "R5");
        select(0);
    endtask

    task automatic t_hold;
        logic [7:0] b  = 8'b1_0001_100;
        logic [7:0] b2 = 8'b1_1111_101;
        int p0 = pulses;
        select(1);
        send_byte(b);
        expect_cmd(p0, b, "R6");
        send_byte(8'hFF);
        send_byte(b2);
        tick(6);
        check(pulses == p0 + 1, "R6", pulses - p0, 1);
        select(0);
        select(1);
        send_byte(b2);
        expect_cmd(p0 + 1, b2, "R6 reselect");
        select(0);
    endtask

    task automatic t_abort;
        logic [7:0] b = 8'b1_0101_001;
        int p0 = pulses;
        select(1);
        send_bit(1); send_bit(1); send_bit(1); send_bit(0);
        select(0);
        tick(6);
        check(pulses == p0, "R7", pulses - p0, 0);
        select(1);
        send_byte(b);
        expect_cmd(p0, b, "R7");
        select(0);
    endtask

    task automatic t_static_clock;
        logic [7:0] b = 8'b1_1001_111;
        int p0 = pulses;
        select(1);
        for (int i = 7; i >= 4; i--) send_bit(b[i]);
        sdi = 1'b1;
        tick(3000);
        check(pulses == p0, "R8 pause", pulses - p0, 0);
        for (int i = 3; i >= 0; i--) send_bit(b[i]);
        expect_cmd(p0, b, "R8");
        select(0);
    endtask

    task automatic t_busy;
        logic [7:0] b = 8'b1_0011_010;
        int p0 = pulses;
        busy = 1'b1;
        select(1);
        send_byte(b);
        tick(6);
        check(pulses == p0, "R9", pulses - p0, 0);
        select(0);
        busy = 1'b0;
        select(1);
        send_byte(b);
        expect_cmd(p0, b, "R9 idle");
        select(0);
    endtask

    task automatic t_deselected_clocks;
        logic [7:0] b = 8'b1_0111_000;
        int p0 = pulses;
        send_byte(8'hFF);
        send_bit(1); send_bit(0); send_bit(1);
        tick(6);
        check(pulses == p0, "R10", pulses - p0, 0);
        select(1);
        send_byte(b);
        expect_cmd(p0, b, "R10");
        select(0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_all_ops();
                t_leading_zeros();
                t_latency();
                t_hold();
                t_abort();
                t_static_clock();
                t_busy();
                t_deselected_clocks();
                check(wide == 0, "R5 pulse width", wide, 0);
            end
            begin
                tick(150000);
                check(1'b0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule